// File: doc/BRIEF.md
# Iterative Operand Address Modifier

This block turns a 36-bit instruction word into its final operand reference. Bits are numbered with bit 0 as the most significant bit, so numbered bit k of the word is vector bit 35-k. On each pass the block first applies optional indexing to the 16-bit address field (numbered bits 16-31). It then checks the indirection flag (numbered bit 12). If the flag is set, it performs one indirection step and starts another pass. Indirection comes in two styles. Memory indirection fetches a word and splices its bits 12-32 into the working word. Register indirection rearranges fields inside the word and loads the address from a scratchpad register. It can also ask for the next indexed address to be written back to that register.

A caller pulses `start_i` with the word and two operation attributes: half-word and non-immediate. The block reads and writes a 32 x 16-bit scratchpad through a single read port and a single write port. It issues memory reads through a request/acknowledge pair. When the loop ends, `done_o` pulses for one cycle with the modified word, an is-literal flag and the formed 32-bit operand. A chain with too many indirections ends with `fault_o` instead of hanging.

Top module: `am_opnd_modifier`

## Requirements
- R1: An index field (numbered bits 13-15) of 1 to 7 adds scratchpad register 1 to 7 to the address field modulo 2^16, with the carry discarded.
- R2: An index field of 0 leaves the address field unchanged, whatever scratchpad register 0 holds.
- R3: With bits 12 and 32 both set, after indexing, the block requests a read at the address field. It holds `mem_req_o` and `mem_addr_o` steady until `mem_ack_i`. Bits 12-32 of the fetched word then replace bits 12-32 of the working word, and bits 0-11 and 33-35 are kept.
- R4: With bit 12 set and bit 32 clear, bits 28-31 move to bits 12-15 and bit 17 moves to bit 32. The address field is replaced by the scratchpad register named by bits 23-27, using all 32 registers.
- R5: If bit 16 was set in a register-indirect step, the address produced by the next indexing is written once into the register named in that step.
- R6: If bit 16 was clear in the register-indirect step, no scratchpad write happens.
- R7: When the loop ends with bit 32 clear on a full-word operation, `literal_o` is 1 and `operand_o` is the address field zero-extended.
- R8: On a half-word operation, such a literal is sign-extended from the address field.
- R9: For a non-immediate operation, `literal_o` is 0 and `operand_o` is the zero-extended address field, whatever bit 32 holds.
- R10: After 64 indirection steps, a 65th request ends the operation with `fault_o` set during `done_o`, and no further memory read is issued.
- R11: After reset, `busy_o`, `done_o`, `mem_req_o` and `sp_we_o` are 0. `busy_o` is 1 from the cycle after start until done, and `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| word_i | input | 36 | Instruction word, numbered bit 0 = vector bit 35 |
| half_i | input | 1 | Half-word operation |
| nimm_i | input | 1 | Non-immediate operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid, single cycle |
| fault_o | output | 1 | Indirection limit exceeded, valid with done_o |
| word_o | output | 36 | Final modified word |
| literal_o | output | 1 | Operand is a literal |
| operand_o | output | 32 | Formed operand or zero-extended address |
| sp_raddr_o | output | 5 | Scratchpad read address |
| sp_rdata_i | input | 16 | Scratchpad read data, combinational |
| sp_we_o | output | 1 | Scratchpad write enable |
| sp_waddr_o | output | 5 | Scratchpad write address |
| sp_wdata_o | output | 16 | Scratchpad write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge with data |
| mem_rdata_i | input | 36 | Memory read data |

## Verification
Indexing is tried with index fields of 0 and non-zero, and with a register value that makes the sum wrap. This separates the path that adds from the path that skips, and shows whether the carry is dropped. A memory-indirect chain uses a fetched word whose outer bits differ from the working word, which shows whether only bits 12-32 are spliced. A request acknowledged after a delay shows whether the address is formed after indexing. Register-indirect runs with the replace bit set and clear are told apart by the scratchpad contents and the write count afterwards. A fetch that always re-requests indirection exposes the iteration limit and the exact number of reads issued. Literal runs cover full-word, half-word with both sign values, and non-immediate, so each way of extending the operand is seen.

// File: rtl/am_pkg.sv
package am_pkg;
  localparam int WORD_W  = 36;
  localparam int ADDR_W  = 16;
  localparam int REG_W   = 5;
  // vector positions, numbered bit k at vector bit 35-k
  localparam int POS_IND = 23;  // bit 12
  localparam int XR_HI   = 22;  // bits 13-15
  localparam int XR_LO   = 20;
  localparam int AD_HI   = 19;  // bits 16-31
  localparam int AD_LO   = 4;
  localparam int POS_REP = 19;  // bit 16
  localparam int POS_NA  = 18;  // bit 17
  localparam int RG_HI   = 12;  // bits 23-27
  localparam int RG_LO   = 8;
  localparam int AMF_HI  = 7;   // bits 28-31
  localparam int AMF_LO  = 4;
  localparam int POS_A   = 3;   // bit 32
  localparam int SPL_HI  = 23;  // bits 12-32
  localparam int SPL_LO  = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_IDX, S_RIND, S_MEM, S_DONE
  } am_state_e;
endpackage

// File: rtl/am_index.sv
module am_index
  import am_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] xval_i,
  output logic [2:0]        xr_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base;
  assign xr_o   = word_i[XR_HI:XR_LO];
  assign base   = word_i[AD_HI:AD_LO];
  assign addr_o = (xr_o != 3'd0) ? ADDR_W'(base + xval_i) : base;
endmodule

// File: rtl/am_rind.sv
module am_rind
  import am_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] rval_i,
  output logic [WORD_W-1:0] word_o,
  output logic              rep_o,
  output logic [REG_W-1:0]  reg_o
);
  assign rep_o = word_i[POS_REP];
  assign reg_o = word_i[RG_HI:RG_LO];

  always_comb begin
    word_o = word_i;
    word_o[POS_IND:XR_LO] = word_i[AMF_HI:AMF_LO];
    word_o[POS_A]         = word_i[POS_NA];
    word_o[AD_HI:AD_LO]   = rval_i;
  end
endmodule

// File: rtl/am_ctrl.sv
module am_ctrl
  import am_pkg::*;
#(
  parameter int MAX_IND = 64,
  localparam int CNT_W  = $clog2(MAX_IND + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              half_i,
  input  logic              nimm_i,
  input  logic [2:0]        xr_i,
  input  logic [ADDR_W-1:0] idx_addr_i,
  input  logic [WORD_W-1:0] rind_word_i,
  input  logic              rind_rep_i,
  input  logic [REG_W-1:0]  rind_reg_i,
  output logic [WORD_W-1:0] work_o,
  output logic              half_o,
  output logic              nimm_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [REG_W-1:0]  sp_raddr_o,
  input  logic [ADDR_W-1:0] sp_rdata_i,
  output logic              sp_we_o,
  output logic [REG_W-1:0]  sp_waddr_o,
  output logic [ADDR_W-1:0] sp_wdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  am_state_e         state_q, state_d;
  logic [WORD_W-1:0] work_q, work_d;
  logic              rep_q, rep_d;
  logic [REG_W-1:0]  rreg_q, rreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              fault_q, fault_d;
  logic              half_q, nimm_q;

  always_comb begin
    state_d    = state_q;
    work_d     = work_q;
    rep_d      = rep_q;
    rreg_d     = rreg_q;
    cnt_d      = cnt_q;
    fault_d    = fault_q;
    sp_raddr_o = {2'b00, xr_i};
    sp_we_o    = 1'b0;
    sp_waddr_o = rreg_q;
    sp_wdata_o = idx_addr_i;
    mem_req_o  = 1'b0;
    mem_addr_o = work_q[AD_HI:AD_LO];
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          work_d  = word_i;
          rep_d   = 1'b0;
          cnt_d   = '0;
          fault_d = 1'b0;
          state_d = S_IDX;
        end
      end
      S_IDX: begin
        work_d[AD_HI:AD_LO] = idx_addr_i;
        if (rep_q) begin
          sp_we_o = 1'b1;
          rep_d   = 1'b0;
        end
        if (!work_q[POS_IND]) begin
          state_d = S_DONE;
        end else if (cnt_q == CNT_W'(MAX_IND)) begin
          fault_d = 1'b1;
          state_d = S_DONE;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = work_q[POS_A] ? S_MEM : S_RIND;
        end
      end
      S_RIND: begin
        sp_raddr_o = rind_reg_i;
        work_d     = rind_word_i;
        rep_d      = rind_rep_i;
        rreg_d     = rind_reg_i;
        state_d    = S_IDX;
      end
      S_MEM: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          work_d[SPL_HI:SPL_LO] = mem_rdata_i[SPL_HI:SPL_LO];
          state_d = S_IDX;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      work_q  <= '0;
      rep_q   <= 1'b0;
      rreg_q  <= '0;
      cnt_q   <= '0;
      fault_q <= 1'b0;
      half_q  <= 1'b0;
      nimm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      work_q  <= work_d;
      rep_q   <= rep_d;
      rreg_q  <= rreg_d;
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
      if (state_q == S_IDLE && start_i) begin
        half_q <= half_i;
        nimm_q <= nimm_i;
      end
    end
  end

  assign work_o  = work_q;
  assign half_o  = half_q;
  assign nimm_o  = nimm_q;
  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_DONE);
  assign fault_o = fault_q;

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  p_wb_after_rind_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> $past(state_q) == S_RIND);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_fault_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && busy_o |-> done_o);
  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_IND));
  p_no_req_on_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> !mem_req_o);
  p_excl_ports_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && sp_we_o));
endmodule

// File: rtl/am_opnd_modifier.sv
module am_opnd_modifier
  import am_pkg::*;
#(
  parameter int MAX_IND = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [35:0]       word_i,
  input  logic              half_i,
  input  logic              nimm_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [35:0]       word_o,
  output logic              literal_o,
  output logic [31:0]       operand_o,
  output logic [4:0]        sp_raddr_o,
  input  logic [15:0]       sp_rdata_i,
  output logic              sp_we_o,
  output logic [4:0]        sp_waddr_o,
  output logic [15:0]       sp_wdata_o,
  output logic              mem_req_o,
  output logic [15:0]       mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [35:0]       mem_rdata_i
);
  logic [WORD_W-1:0] work;
  logic [2:0]        xr;
  logic [ADDR_W-1:0] idx_addr, fin_addr;
  logic [WORD_W-1:0] rind_word;
  logic              rind_rep;
  logic [REG_W-1:0]  rind_reg;
  logic              half_q, nimm_q, is_addr;

  am_index u_index (
    .word_i (work),
    .xval_i (sp_rdata_i),
    .xr_o   (xr),
    .addr_o (idx_addr)
  );

  am_rind u_rind (
    .word_i (work),
    .rval_i (sp_rdata_i),
    .word_o (rind_word),
    .rep_o  (rind_rep),
    .reg_o  (rind_reg)
  );

  am_ctrl #(.MAX_IND(MAX_IND)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .word_i      (word_i),
    .half_i      (half_i),
    .nimm_i      (nimm_i),
    .xr_i        (xr),
    .idx_addr_i  (idx_addr),
    .rind_word_i (rind_word),
    .rind_rep_i  (rind_rep),
    .rind_reg_i  (rind_reg),
    .work_o      (work),
    .half_o      (half_q),
    .nimm_o      (nimm_q),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .sp_raddr_o  (sp_raddr_o),
    .sp_rdata_i  (sp_rdata_i),
    .sp_we_o     (sp_we_o),
    .sp_waddr_o  (sp_waddr_o),
    .sp_wdata_o  (sp_wdata_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i)
  );

  assign fin_addr  = work[AD_HI:AD_LO];
  assign is_addr   = work[POS_A] | nimm_q;
  assign word_o    = work;
  assign literal_o = ~is_addr;
  assign operand_o = (!is_addr && half_q) ? {{16{fin_addr[15]}}, fin_addr}
                                          : {16'h0000, fin_addr};

  p_nimm_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && nimm_q |-> !literal_o && operand_o[31:16] == 16'h0000);
  p_done_no_ind_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> !word_o[POS_IND]);
endmodule

// File: tb/am_opnd_modifier_bench.sv
module am_opnd_modifier_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [35:0] word_in = '0;
  logic        half = 1'b0, nimm = 1'b0;
  logic        busy, done, fault, literal;
  logic [35:0] word_out;
  logic [31:0] operand;
  logic [4:0]  sp_raddr, sp_waddr;
  logic [15:0] sp_rdata, sp_wdata;
  logic        sp_we, mem_req, mem_ack;
  logic [15:0] mem_addr;
  logic [35:0] mem_word = '0;
  logic [15:0] sp [32];
  logic [1:0]  mdly;
  int          n_rd = 0, n_wr = 0;
  logic [15:0] last_rd_addr = '0;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  am_opnd_modifier u_am_opnd_modifier (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_i(word_in),
    .half_i(half), .nimm_i(nimm), .busy_o(busy), .done_o(done),
    .fault_o(fault), .word_o(word_out), .literal_o(literal),
    .operand_o(operand), .sp_raddr_o(sp_raddr), .sp_rdata_i(sp_rdata),
    .sp_we_o(sp_we), .sp_waddr_o(sp_waddr), .sp_wdata_o(sp_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_word)
  );

  assign sp_rdata = sp[sp_raddr];
  assign mem_ack  = mem_req && (mdly == 2'd2);

  always @(posedge clk) begin
    if (!rst_n) mdly <= '0;
    else if (mem_req && !mem_ack) mdly <= mdly + 2'd1;
    else mdly <= '0;
    if (mem_req && mem_ack) begin
      n_rd <= n_rd + 1;
      last_rd_addr <= mem_addr;
    end
    if (sp_we) begin
      sp[sp_waddr] <= sp_wdata;
      n_wr <= n_wr + 1;
    end
  end

  // numbered bit k lives at vector bit 35-k
  function automatic logic [35:0] mk(input logic ind, input logic [2:0] xr,
                                     input logic [15:0] ad, input logic a);
    logic [35:0] w;
    w = '0;
    w[35:24] = 12'hA5C;
    w[23]    = ind;
    w[22:20] = xr;
    w[19:4]  = ad;
    w[3]     = a;
    w[2:0]   = 3'b101;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [35:0] w, input logic h, input logic ni);
    int n;
    @(negedge clk);
    word_in = w; half = h; nimm = ni; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("R11 done timeout", 0, 1);
  endtask

  task automatic t_reset;
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset req", mem_req, 0);
    chk("R11 reset we", sp_we, 0);
  endtask

  task automatic t_index;
    sp[3] = 16'h0010;
    run(mk(0, 3'd3, 16'h1234, 1), 0, 0);
    chk("R1 add", word_out, mk(0, 3'd3, 16'h1244, 1));
    chk("R1 operand", operand, 32'h0000_1244);
    sp[7] = 16'hFFFF;
    run(mk(0, 3'd7, 16'h0002, 1), 0, 0);
    chk("R1 carry dropped", word_out[19:4], 16'h0001);
  endtask

  task automatic t_noindex;
    sp[0] = 16'h5555;
    run(mk(0, 3'd0, 16'h0ABC, 1), 0, 0);
    chk("R2 no index", word_out, mk(0, 3'd0, 16'h0ABC, 1));
  endtask

  task automatic t_literal;
    run(mk(0, 3'd0, 16'h8001, 0), 0, 0);
    chk("R7 literal flag", literal, 1);
    chk("R7 zero extend", operand, 32'h0000_8001);
    run(mk(0, 3'd0, 16'h8001, 0), 1, 0);
    chk("R8 sign extend neg", operand, 32'hFFFF_8001);
    run(mk(0, 3'd0, 16'h7001, 0), 1, 0);
    chk("R8 sign extend pos", operand, 32'h0000_7001);
    run(mk(0, 3'd0, 16'h8001, 0), 1, 1);
    chk("R9 nimm literal", literal, 0);
    chk("R9 nimm operand", operand, 32'h0000_8001);
  endtask

  task automatic t_mem;
    int r0;
    logic [35:0] exp;
    r0 = n_rd;
    sp[2] = 16'h0100;
    mem_word = '1;
    mem_word[23] = 1'b0;
    mem_word[22:20] = 3'd0;
    mem_word[19:4] = 16'h4444;
    mem_word[3] = 1'b1;
    run(mk(1, 3'd2, 16'h0020, 1), 0, 0);
    exp = mk(0, 3'd0, 16'h4444, 1);
    chk("R3 read address", last_rd_addr, 16'h0120);
    chk("R3 splice", word_out, exp);
    chk("R3 read count", n_rd - r0, 1);
  endtask

  task automatic t_rind(input logic rep);
    int w0;
    logic [35:0] exp;
    w0 = n_wr;
    sp[20] = 16'h3000;
    sp[4]  = 16'h0005;
    // bit16=rep, bit17=1, bits23-27=20, bits28-31=0100
    run(mk(1, 3'd0, {rep, 1'b1, 5'd0, 5'd20, 4'b0100}, 0), 0, 0);
    exp = mk(0, 3'd4, 16'h3005, 1);
    chk("R4 rearranged word", word_out, exp);
    chk("R4 address form", literal, 0);
    if (rep) begin
      chk("R5 written back", sp[20], 16'h3005);
      chk("R5 single write", n_wr - w0, 1);
    end else begin
      chk("R6 no write value", sp[20], 16'h3000);
      chk("R6 no write count", n_wr - w0, 0);
    end
  endtask

  task automatic t_limit;
    int r0;
    r0 = n_rd;
    mem_word = mk(1, 3'd0, 16'h0040, 1);
    run(mk(1, 3'd0, 16'h0040, 1), 0, 0);
    chk("R10 fault", fault, 1);
    chk("R10 read count", n_rd - r0, 64);
  endtask

  task automatic t_handshake;
    @(negedge clk);
    word_in = mk(0, 3'd0, 16'h0001, 1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 busy after start", busy, 1);
    while (!done) @(negedge clk);
    chk("R11 fault clear", fault, 0);
    @(negedge clk);
    chk("R11 done pulse", done, 0);
    chk("R11 idle after", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) sp[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_index();
    t_noindex();
    t_literal();
    t_mem();
    t_rind(1'b1);
    t_rind(1'b0);
    t_limit();
    t_handshake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule